// File: doc/BRIEF.md
# MDIO Management Master

This block lets software read and write the registers of an Ethernet PHY over the two-wire management link. It has a small register bus with six word locations:

- a configuration word that selects the clock ratio and holds a management reset;
- a command word;
- an address word naming the PHY and its register;
- a write-data word;
- a read-result word;
- an indicator word.

The management clock (MDC) is derived from the system clock. A three-bit code picks one of seven prescale ratios, and each ratio is followed by a fixed divide-by-eight. MDC is held low whenever no frame is in flight.

Each frame is a clause-22 frame of 64 bit times:

- 32 preamble ones;
- start pattern `01`;
- a two-bit opcode;
- a five-bit PHY address;
- a five-bit register number;
- a two-bit turnaround;
- sixteen data bits, most significant first.

Writing the write-data word launches a write frame. Raising the read bit of the command word launches a read frame. The busy indicator covers the whole frame. During the turnaround and data of a read, the master releases the line and shifts in the PHY's bits on rising MDC edges. A read from an address where no PHY answers yields `0xFFFF` through the line's pull-up, and the block returns that value untouched.

The sequencer has five states. IDLE goes to PREAMBLE on a launch. PREAMBLE goes to HEADER after 32 bit times. HEADER goes to TURNAROUND after 14 bit times. TURNAROUND goes to DATA after 2 bit times. DATA goes back to IDLE after 16 bit times. From any state, the management reset forces IDLE.

Top module: `mdio_master`

## Requirements
- R1: After reset every bus word reads 0, MDC is low and the MDIO output enable is low.
- R2: While a frame runs, one MDC period lasts 8×P system clocks. P is 4, 6, 8, 10, 14, 20 or 28 for configuration code bits [2:0] = 1 through 7, and code 0 behaves as code 1. MDC is low while idle.
- R3: The address word (offset 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0, and reads back only those fields.
- R4: Writing the write-data word (offset 3, bits 15:0) while idle sends a frame of 32 ones, `01`, opcode `01`, PHY address, register number, turnaround `10` and the 16 data bits MSB first.
- R5: Changing command word (offset 1) bit 0 from 0 to 1 while idle sends a frame with opcode `10`. The master's output enable is low for bit times 46 to 63. The 16 bits sampled on rising MDC edges during bit times 48 to 63 appear in the read-result word (offset 4, bits 15:0) once the frame ends.
- R6: Indicator word (offset 5) bit 0 is set from the clock edge that launches a frame for exactly 64 MDC periods, then clears.
- R7: A read of an address where no PHY drives the line returns 0xFFFF.
- R8: While configuration bit 31 is set, any frame in flight is abandoned within one clock, busy, MDC and output enable go low, and launches and write-data stores are ignored. Clearing the bit returns the block to normal use.
- R9: Launch attempts made while busy start no frame, and a write-data store made while busy leaves the write-data word unchanged.
- R10: The master changes its MDIO output only while MDC is low (on falling edges or at launch), never on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The hardest case to reach is a management reset that lands in the middle of a frame. The aborted frame must leave no trace at the PHY, and the next frame must still be well formed. The bench starts a write at the fastest clock code and raises the reset bit a few hundred cycles in, well inside the preamble. It then checks the indicator, MDC and the output enable one cycle later, and tries a launch while the reset is held. After releasing the reset, it confirms that the PHY model saw no completed frame and that its target register was not changed. The busy-launch case is reached in a similar way: the bench issues a second read trigger and a data store partway through a read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CODE_W    = 3;
    localparam int PHY_W     = 5;
    localparam int REGN_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 4 + PHY_W + REGN_W;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int HALF_W    = 8;

    localparam int OFF_CFG  = 0;
    localparam int OFF_CMD  = 1;
    localparam int OFF_ADR  = 2;
    localparam int OFF_WDAT = 3;
    localparam int OFF_RDAT = 4;
    localparam int OFF_IND  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_HDR, ST_TA, ST_DATA
    } mdio_state_t;

    // Half an MDC period in system clocks: prescale * 8 / 2.
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_W-1:0] code);
        case (code)
            3'd2:    half_period = HALF_W'(6 * 4);
            3'd3:    half_period = HALF_W'(8 * 4);
            3'd4:    half_period = HALF_W'(10 * 4);
            3'd5:    half_period = HALF_W'(14 * 4);
            3'd6:    half_period = HALF_W'(20 * 4);
            3'd7:    half_period = HALF_W'(28 * 4);
            default: half_period = HALF_W'(4 * 4);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] hcnt;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = half_period(code);
    assign wrap = en && (hcnt >= half - HALF_W'(1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            mdc  <= 1'b0;
        end else if (!en) begin
            hcnt <= '0;
            mdc  <= 1'b0;
        end else if (wrap) begin
            hcnt <= '0;
            mdc  <= ~mdc;
        end else begin
            hcnt <= hcnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_value,
    output logic [CODE_W-1:0] code,
    output logic              mgmt_rst,
    output logic [PHY_W-1:0]  phy_addr,
    output logic [REGN_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              start_wr,
    output logic              start_rd
);
    localparam int PHY_LSB = 8;

    logic [BUS_W-1:0]  cfg_q;
    logic              cmd_rd;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              hit_cfg, hit_cmd, hit_adr, hit_wdat;

    assign hit_cfg  = wr && (sel == SEL_W'(OFF_CFG));
    assign hit_cmd  = wr && (sel == SEL_W'(OFF_CMD));
    assign hit_adr  = wr && (sel == SEL_W'(OFF_ADR));
    assign hit_wdat = wr && (sel == SEL_W'(OFF_WDAT));

    assign code     = cfg_q[CODE_W-1:0];
    assign mgmt_rst = cfg_q[BUS_W-1];
    assign wr_data  = wdata[DATA_W-1:0];
    assign start_wr = hit_wdat && !busy && !mgmt_rst;
    assign start_rd = hit_cmd && wdata[0] && !cmd_rd && !busy && !mgmt_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cmd_rd   <= 1'b0;
            phy_addr <= '0;
            reg_addr <= '0;
            wdat_q   <= '0;
            rdat_q   <= '0;
        end else begin
            if (hit_cfg) cfg_q <= wdata;
            if (hit_cmd) cmd_rd <= wdata[0];
            if (hit_adr) begin
                phy_addr <= wdata[PHY_LSB +: PHY_W];
                reg_addr <= wdata[REGN_W-1:0];
            end
            if (start_wr) wdat_q <= wdata[DATA_W-1:0];
            if (rd_done)  rdat_q <= rd_value;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_W'(OFF_CFG):  rdata = cfg_q;
            SEL_W'(OFF_CMD):  rdata[0] = cmd_rd;
            SEL_W'(OFF_ADR):  begin
                rdata[PHY_LSB +: PHY_W] = phy_addr;
                rdata[REGN_W-1:0]       = reg_addr;
            end
            SEL_W'(OFF_WDAT): rdata[DATA_W-1:0] = wdat_q;
            SEL_W'(OFF_RDAT): rdata[DATA_W-1:0] = rdat_q;
            SEL_W'(OFF_IND):  rdata[0] = busy;
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REGN_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);
    mdio_state_t            state, state_nx;
    logic [BIT_W-1:0]       bit_cnt;
    logic [FRAME_LEN-1:0]   shreg;
    logic                   is_rd;
    logic [DATA_W-1:0]      cap;
    logic                   last_pre, last_hdr, last_ta, last_dat;

    assign last_pre = fall && (bit_cnt == BIT_W'(PRE_LEN - 1));
    assign last_hdr = fall && (bit_cnt == BIT_W'(PRE_LEN + HDR_LEN - 1));
    assign last_ta  = fall && (bit_cnt == BIT_W'(PRE_LEN + HDR_LEN + TA_LEN - 1));
    assign last_dat = fall && (bit_cnt == BIT_W'(FRAME_LEN - 1));

    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start_wr || start_rd) state_nx = ST_PRE;
                ST_PRE:  if (last_pre) state_nx = ST_HDR;
                ST_HDR:  if (last_hdr) state_nx = ST_TA;
                ST_TA:   if (last_ta)  state_nx = ST_DATA;
                ST_DATA: if (last_dat) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            is_rd   <= 1'b0;
            cap     <= '0;
        end else if (state == ST_IDLE) begin
            if (!abort && (start_wr || start_rd)) begin
                bit_cnt <= '0;
                is_rd   <= start_rd;
                shreg   <= {{PRE_LEN{1'b1}}, 2'b01,
                            (start_rd ? 2'b10 : 2'b01),
                            phy_addr, reg_addr,
                            (start_rd ? 2'b11 : 2'b10),
                            (start_rd ? {DATA_W{1'b1}} : wr_data)};
            end
        end else begin
            if (fall) begin
                shreg   <= {shreg[FRAME_LEN-2:0], 1'b1};
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
            if (rise && is_rd && state == ST_DATA)
                cap <= {cap[DATA_W-2:0], mdio_i};
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        mdio_o   = shreg[FRAME_LEN-1];
        mdio_oe  = busy && !(is_rd && (state == ST_TA || state == ST_DATA));
        rd_done  = (state == ST_DATA) && last_dat && is_rd && !abort;
        rd_value = cap;
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [CODE_W-1:0] code;
    logic              mgmt_rst;
    logic [PHY_W-1:0]  phy_addr;
    logic [REGN_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic              start_wr, start_rd;
    logic              busy, rd_done;
    logic [DATA_W-1:0] rd_value;
    logic              rise, fall;

    mdio_regs #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy),
        .rd_done(rd_done), .rd_value(rd_value), .code(code),
        .mgmt_rst(mgmt_rst), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .start_wr(start_wr), .start_rd(start_rd)
    );

    mdio_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .en(busy && !mgmt_rst), .code(code),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .abort(mgmt_rst),
        .start_wr(start_wr), .start_rd(start_rd),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_done(rd_done), .rd_value(rd_value)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_wr,
    input logic busy,
    input logic mgmt_rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_oe_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_mgmt_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst |=> !busy);

    assert_launch_by_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr));

    assert_change_mdc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);

    assert_steady_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .busy(busy),
    .mgmt_rst(mgmt_rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int PHY_ID = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, dut_o, dut_oe, mdio_line;
    logic        phy_oe, phy_val;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    assign mdio_line = dut_oe ? dut_o : (phy_oe ? phy_val : 1'b1);

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(dut_o), .mdio_oe(dut_oe), .mdio_i(mdio_line)
    );

    // PHY responder: samples on rising MDC, drives on falling MDC.
    logic        mdc_q;
    int          nbit, idle, frames, cyc, last_rise, period;
    logic [63:0] fbits, oebits, last_frame;
    logic [15:0] mem [32];

    always @(posedge clk) begin : phy_model
        logic [63:0] f;
        if (!rst_n) begin
            mdc_q <= 1'b0; nbit <= 0; idle <= 0; frames <= 0; cyc <= 0;
            last_rise <= 0; period <= 0; phy_oe <= 1'b0; phy_val <= 1'b1;
            fbits <= '0; oebits <= '0; last_frame <= '0;
            for (int k = 0; k < 32; k++) mem[k] <= 16'hA500 + 16'(k);
        end else begin
            cyc   <= cyc + 1;
            mdc_q <= mdc;
            if (!mdc && !mdc_q) begin
                idle <= idle + 1;
                if (idle > 300) nbit <= 0;
            end else idle <= 0;
            if (mdc && !mdc_q) begin
                f = fbits;
                f[63-nbit] = mdio_line;
                fbits <= f;
                oebits[63-nbit] <= dut_oe;
                period <= cyc - last_rise;
                last_rise <= cyc;
                if (nbit == 63) begin
                    nbit <= 0;
                    frames <= frames + 1;
                    last_frame <= f;
                    if (f[29:28] == 2'b01 && f[27:23] == 5'(PHY_ID))
                        mem[f[22:18]] <= f[15:0];
                end else nbit <= nbit + 1;
            end
            if (!mdc && mdc_q) begin
                if (fbits[29:28] == 2'b10 && fbits[27:23] == 5'(PHY_ID)
                    && nbit >= 47 && nbit <= 63) begin
                    phy_oe  <= 1'b1;
                    phy_val <= (nbit == 47) ? 1'b0 : mem[fbits[22:18]][63-nbit];
                end else phy_oe <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act === exp) n_pass++;
        else $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        logic [31:0] v;
        cnt = 0;
        bus_read(3'd5, v);
        while (v[0] && cnt < 20000) begin
            @(negedge clk);
            cnt++;
            bus_read(3'd5, v);
        end
    endtask

    function automatic int half_of(input int code);
        int p [8] = '{4, 4, 6, 8, 10, 14, 20, 28};
        return p[code] * 4;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), v);
            check("R1", $sformatf("word %0d after reset", a), 64'(v), 64'd0);
        end
        check("R1", "mdc after reset", 64'(mdc), 64'd0);
        check("R1", "oe after reset", 64'(dut_oe), 64'd0);
    endtask

    task automatic t_addr_fields();
        logic [31:0] v;
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, v);
        check("R3", "address word masks to fields", 64'(v), 64'h1F1F);
    endtask

    task automatic t_write(input int code, input int phy, input int rg,
                           input logic [15:0] d);
        logic [31:0] v;
        int cnt;
        int fr0;
        bus_write(3'd0, 32'(code));
        bus_write(3'd2, (32'(phy) << 8) | 32'(rg));
        fr0 = frames;
        bus_write(3'd3, {16'h0, d});
        bus_read(3'd5, v);
        check("R6", "busy right after launch", 64'(v[0]), 64'd1);
        wait_idle(cnt);
        check("R6", $sformatf("busy length code %0d", code), 64'(cnt),
              64'(128 * half_of(code)));
        check("R2", $sformatf("mdc period code %0d", code), 64'(period),
              64'(2 * half_of(code)));
        check("R2", "mdc low after frame", 64'(mdc), 64'd0);
        check("R4", "one frame seen", 64'(frames - fr0), 64'd1);
        check("R4", "write frame bits", last_frame,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(phy), 5'(rg), 2'b10, d});
        check("R4", "master drove all bits", oebits, {64{1'b1}});
        bus_read(3'd3, v);
        check("R4", "write-data word", 64'(v), 64'(d));
    endtask

    task automatic t_read(input int code, input int phy, input int rg,
                          input logic [15:0] exp, input string req);
        logic [31:0] v;
        int cnt;
        bus_write(3'd0, 32'(code));
        bus_write(3'd2, (32'(phy) << 8) | 32'(rg));
        bus_write(3'd1, 32'd0);
        bus_write(3'd1, 32'd1);
        wait_idle(cnt);
        check("R6", "read busy length", 64'(cnt), 64'(128 * half_of(code)));
        check("R5", "read opcode", 64'(last_frame[29:28]), 64'd2);
        check("R5", "released bits 46..63", 64'(oebits[17:0]), 64'd0);
        bus_read(3'd4, v);
        check(req, $sformatf("read data phy %0d reg %0d", phy, rg), 64'(v), 64'(exp));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int cnt;
        int fr0;
        bus_write(3'd0, 32'd2);
        bus_write(3'd2, (32'(PHY_ID) << 8) | 32'd9);
        bus_write(3'd1, 32'd0);
        fr0 = frames;
        bus_write(3'd1, 32'd1);
        repeat (500) @(negedge clk);
        bus_write(3'd3, 32'h0000_1234);
        bus_write(3'd1, 32'd0);
        bus_write(3'd1, 32'd1);
        wait_idle(cnt);
        repeat (600) @(negedge clk);
        check("R9", "only one frame after busy launches", 64'(frames - fr0), 64'd1);
        check("R9", "mdc idle after", 64'(mdc), 64'd0);
        bus_read(3'd4, v);
        check("R9", "read result intact", 64'(v), 64'hA509);
        bus_read(3'd3, v);
        check("R9", "write-data word unchanged", 64'(v), 64'h5A5A);
    endtask

    task automatic t_mgmt_reset();
        logic [31:0] v;
        int fr0;
        bus_write(3'd0, 32'd1);
        bus_write(3'd2, (32'(PHY_ID) << 8) | 32'd7);
        fr0 = frames;
        bus_write(3'd3, 32'h0000_5555);
        repeat (300) @(negedge clk);
        bus_write(3'd0, 32'h8000_0001);
        @(negedge clk);
        bus_read(3'd5, v);
        check("R8", "busy cleared by reset bit", 64'(v[0]), 64'd0);
        check("R8", "mdc low under reset", 64'(mdc), 64'd0);
        check("R8", "oe low under reset", 64'(dut_oe), 64'd0);
        bus_write(3'd3, 32'h0000_7777);
        @(negedge clk);
        bus_read(3'd5, v);
        check("R8", "launch ignored under reset", 64'(v[0]), 64'd0);
        bus_read(3'd3, v);
        check("R8", "store ignored under reset", 64'(v), 64'h5555);
        bus_write(3'd0, 32'd1);
        repeat (400) @(negedge clk);
        check("R8", "aborted frame not completed", 64'(frames - fr0), 64'd0);
        check("R8", "phy register untouched", 64'(mem[7]), 64'hA507);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_fields();
        t_write(1, PHY_ID, 5, 16'hBEEF);
        t_read(2, PHY_ID, 5, 16'hBEEF, "R5");
        t_read(3, PHY_ID, 12, 16'hA50C, "R5");
        t_read(2, 7, 5, 16'hFFFF, "R7");
        t_write(5, PHY_ID, 20, 16'h5A5A);
        t_busy_ignore();
        t_mgmt_reset();
        t_write(0, PHY_ID, 7, 16'h0F0F);
        t_write(7, 1, 2, 16'h8001);
        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_pass, n_total + 1);
            $finish;
        end
    end
endmodule